// File: doc/BRIEF.md
# Signed Multiply Unit with Flags

This execution-unit block multiplies two signed operands and produces the condition flags that go with the product. Three operand forms are selected at start by two control inputs. The word form multiplies the low halves of the two sources into a full-width product. The long form multiplies the full sources and returns either the truncated low word or the complete double-width product as a high and a low word.

The product is built over several cycles by a radix-2 Booth shift-add datapath. A caller raises `start` for one cycle while the unit is idle. It then watches `done`. In that one cycle the result words, the write-enables for the low and high destinations, the flags and a flag-update mask are presented together. The caller also supplies the two destination register indices. If the double-width form names the same register for both halves, the outcome would be meaningless. In that case the unit reports an error and blocks every write.

Top module: `smul_flags_unit`

## Requirements
- R1: Word form (`long_sel`=0). Only bits [15:0] of each source are used, as signed values, and bits [31:16] have no effect. The 32-bit signed product appears on `result_lo` with `we_lo`=1, `we_hi`=0 and `result_hi`=0.
- R2: Long truncated form (`long_sel`=1, `wide_sel`=0). `result_lo` carries the low 32 bits of the 64-bit signed product, with `we_lo`=1, `we_hi`=0 and `result_hi`=0.
- R3: Long wide form (`long_sel`=1, `wide_sel`=1) with distinct indices. `result_hi`:`result_lo` carries the full 64-bit signed product, and `we_hi`=1 together with `we_lo`=1.
- R4: The overflow flag (`flags[1]`) is 1 only in the long truncated form, and only when the upper 32 product bits differ from 32 copies of product bit 31. In every other case it is 0.
- R5: The negative flag (`flags[3]`) and the zero flag (`flags[2]`) describe the returned result. In the wide form they use bit 63 and a test of all 64 bits. In the other forms they use bit 31 and a test of 32 bits.
- R6: The carry flag (`flags[0]`) is always 0 when `done` is high. The update mask `upd_mask` is ordered {X,N,Z,V,C}. It reads 5'b01111 with every valid result, so the extend flag is never updated.
- R7: Wide form with `dst_lo_idx` equal to `dst_hi_idx` raises `err` with `done`, and forces `we_lo`=0, `we_hi`=0 and `upd_mask`=0. The other forms ignore `dst_hi_idx`.
- R8: A start accepted at one clock edge makes `busy` high after that edge. `done`, `we_lo`, `we_hi`, `err` and `upd_mask` pulse for exactly one cycle, DATA_W edges after the accepting edge, and `busy` is low in that cycle.
- R9: A `start` received while `busy` is high is ignored. The running product completes with its original operands, and no extra `done` follows.
- R10: Synchronous active-high `rst` clears `busy`, `done`, both result words, the write-enables, `err`, `flags` and `upd_mask`, and it abandons an operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply when idle |
| long_sel | input | 1 | 0: word form, 1: long form |
| wide_sel | input | 1 | Long form only: 1 returns the 64-bit product |
| src_a | input | DATA_W | Multiplicand |
| src_b | input | DATA_W | Multiplier |
| dst_lo_idx | input | IDX_W | Destination index for the low word |
| dst_hi_idx | input | IDX_W | Destination index for the high word |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result_lo | output | DATA_W | Low result word |
| result_hi | output | DATA_W | High result word (wide form) |
| we_lo | output | 1 | Write low destination |
| we_hi | output | 1 | Write high destination |
| flags | output | 4 | {N,Z,V,C} |
| upd_mask | output | 5 | Flags to update, {X,N,Z,V,C} |
| err | output | 1 | Wide form with equal destination indices |

## Verification
The hardest case to reach is a Booth accumulator that runs past the data width. This happens when both operands are the most negative value, and also with the most negative value times -1. These products reach exactly +2^62 and +2^31, so the guard bit of the accumulator is exercised. They also set overflow in the truncated form. The vector table places those operand pairs in all three forms. A second hard case is a start strobe that arrives mid-operation with different operands. The bench raises it several cycles into a run and then confirms that the original product, the original latency and a single `done` are observed.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    FORM_WORD   = 2'd0,
    FORM_LONG32 = 2'd1,
    FORM_LONG64 = 2'd2
  } smul_form_e;

  // positions inside flags {N,Z,V,C} and upd_mask {X,N,Z,V,C}
  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
  localparam int MASK_X = 4;

  function automatic smul_form_e pick_form(input logic long_sel, input logic wide_sel);
    if (!long_sel) return FORM_WORD;
    return wide_sel ? FORM_LONG64 : FORM_LONG32;
  endfunction

endpackage

// File: rtl/smul_booth_core.sv
module smul_booth_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           last_step,
  output logic [2*W-1:0] prod_next
);
  localparam int CNT_W  = $clog2(W);
  localparam int STEP_W = 2*W + 2;

  logic [W:0]       acc;
  logic [W:0]       mreg;
  logic [W-1:0]     qr;
  logic             qm1;
  logic [CNT_W-1:0] cnt;
  logic [STEP_W-1:0] step;

  // one radix-2 Booth iteration: add/subtract, then arithmetic shift right
  function automatic logic [STEP_W-1:0] booth_step(
    input logic [W:0] a, input logic [W-1:0] q, input logic q_prev, input logic [W:0] m);
    logic [W:0] sum;
    case ({q[0], q_prev})
      2'b01:   sum = a + m;
      2'b10:   sum = a - m;
      default: sum = a;
    endcase
    return {sum[W], sum[W:1], sum[0], q[W-1:1], q[0]};
  endfunction

  assign step      = booth_step(acc, qr, qm1, mreg);
  assign last_step = busy && (cnt == CNT_W'(W-1));
  assign prod_next = step[2*W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      mreg <= '0;
      qr   <= '0;
      qm1  <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      acc  <= '0;
      mreg <= {mcand[W-1], mcand};
      qr   <= mplier;
      qm1  <= 1'b0;
    end else if (busy) begin
      acc <= step[STEP_W-1:W+1];
      qr  <= step[W:1];
      qm1 <= step[0];
      cnt <= cnt + 1'b1;
      if (last_step) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/smul_result_fmt.sv
module smul_result_fmt
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  smul_form_e     form,
  input  logic           idx_clash,
  output logic [W-1:0]   res_lo,
  output logic [W-1:0]   res_hi,
  output logic [3:0]     flags,
  output logic [4:0]     mask,
  output logic           we_lo,
  output logic           we_hi,
  output logic           err
);
  logic lo_neg, lo_zero, wide_zero, trunc_ovf;

  assign lo_neg    = prod[W-1];
  assign lo_zero   = (prod[W-1:0] == '0);
  assign wide_zero = (prod == '0);
  assign trunc_ovf = (prod[2*W-1:W] != {W{prod[W-1]}});

  always_comb begin
    res_lo = prod[W-1:0];
    res_hi = '0;
    flags  = '0;
    case (form)
      FORM_LONG64: begin
        res_hi         = prod[2*W-1:W];
        flags[FLAG_N]  = prod[2*W-1];
        flags[FLAG_Z]  = wide_zero;
      end
      FORM_LONG32: begin
        flags[FLAG_N]  = lo_neg;
        flags[FLAG_Z]  = lo_zero;
        flags[FLAG_V]  = trunc_ovf;
      end
      default: begin
        flags[FLAG_N]  = lo_neg;
        flags[FLAG_Z]  = lo_zero;
      end
    endcase

    err   = (form == FORM_LONG64) && idx_clash;
    we_lo = !err;
    we_hi = (form == FORM_LONG64) && !err;
    mask  = '0;
    if (!err) begin
      mask[FLAG_N] = 1'b1;
      mask[FLAG_Z] = 1'b1;
      mask[FLAG_V] = 1'b1;
      mask[FLAG_C] = 1'b1;
    end
  end

endmodule

// File: rtl/smul_flags_unit.sv
module smul_flags_unit
  import smul_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              long_sel,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IDX_W-1:0]  dst_lo_idx,
  input  logic [IDX_W-1:0]  dst_hi_idx,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result_lo,
  output logic [DATA_W-1:0] result_hi,
  output logic              we_lo,
  output logic              we_hi,
  output logic [3:0]        flags,
  output logic [4:0]        upd_mask,
  output logic              err
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] widen_half(input logic [DATA_W-1:0] v);
    return {{(DATA_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  // named internal events
  logic              accept;
  logic              core_busy;
  logic              last_step;
  logic [2*DATA_W-1:0] prod_next;
  smul_form_e        form_in;
  smul_form_e        form_q;
  logic              clash_q;
  logic [DATA_W-1:0] op_a, op_b;

  logic [DATA_W-1:0] f_lo, f_hi;
  logic [3:0]        f_flags;
  logic [4:0]        f_mask;
  logic              f_we_lo, f_we_hi, f_err;

  assign form_in = pick_form(long_sel, wide_sel);
  assign accept  = start && !core_busy;
  assign op_a    = (form_in == FORM_WORD) ? widen_half(src_a) : src_a;
  assign op_b    = (form_in == FORM_WORD) ? widen_half(src_b) : src_b;
  assign busy    = core_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      form_q  <= FORM_WORD;
      clash_q <= 1'b0;
    end else if (accept) begin
      form_q  <= form_in;
      clash_q <= (dst_lo_idx == dst_hi_idx);
    end
  end

  smul_booth_core #(.W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .mcand     (op_a),
    .mplier    (op_b),
    .busy      (core_busy),
    .last_step (last_step),
    .prod_next (prod_next)
  );

  smul_result_fmt #(.W(DATA_W)) u_fmt (
    .prod      (prod_next),
    .form      (form_q),
    .idx_clash (clash_q),
    .res_lo    (f_lo),
    .res_hi    (f_hi),
    .flags     (f_flags),
    .mask      (f_mask),
    .we_lo     (f_we_lo),
    .we_hi     (f_we_hi),
    .err       (f_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      we_lo     <= 1'b0;
      we_hi     <= 1'b0;
      err       <= 1'b0;
      upd_mask  <= '0;
      flags     <= '0;
      result_lo <= '0;
      result_hi <= '0;
    end else begin
      done     <= last_step;
      we_lo    <= last_step && f_we_lo;
      we_hi    <= last_step && f_we_hi;
      err      <= last_step && f_err;
      upd_mask <= last_step ? f_mask : '0;
      if (last_step) begin
        flags     <= f_flags;
        result_lo <= f_lo;
        result_hi <= f_hi;
      end
    end
  end

endmodule

// File: rtl/smul_flags_chk.sv
module smul_flags_chk
  import smul_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       we_lo,
  input logic       we_hi,
  input logic       err,
  input logic [3:0] flags,
  input logic [4:0] upd_mask,
  input smul_form_e form_q
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  strobe_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (we_lo || we_hi || err || (upd_mask != '0)) |-> done);

  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R6
  carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!flags[FLAG_C] && !upd_mask[MASK_X]));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (done && form_q != FORM_LONG32) |-> !flags[FLAG_V]);

  // R7
  clash_block_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!we_lo && !we_hi && upd_mask == '0));

  // R3
  hi_pair_chk: assert property (@(posedge clk) disable iff (rst)
    we_hi |-> we_lo);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done));

endmodule

bind smul_flags_unit smul_flags_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .we_lo    (we_lo),
  .we_hi    (we_hi),
  .err      (err),
  .flags    (flags),
  .upd_mask (upd_mask),
  .form_q   (form_q)
);

// File: tb/smul_flags_unit_tb.sv
module smul_flags_unit_tb;
  localparam int W  = 32;
  localparam int NV = 14;

  // {src_a, src_b, long_sel, wide_sel}
  localparam logic [65:0] VECS [NV] = '{
    {32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0},
    {32'hABCD_8000, 32'h1234_8000, 1'b0, 1'b0},
    {32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {32'h1234_5678, 32'h0000_0000, 1'b1, 1'b1},
    {32'hFFFF_0000, 32'h0001_FFFF, 1'b0, 1'b1},
    {32'h0000_FFFF, 32'h0000_0003, 1'b0, 1'b0},
    {32'h0001_0000, 32'h0001_0000, 1'b1, 1'b0},
    {32'hDEAD_BEEF, 32'h0123_4567, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {32'h0000_7FFF, 32'hFFFF_8000, 1'b0, 1'b0},
    {32'hCAFE_BABE, 32'h1357_9BDF, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, start, long_sel, wide_sel;
  logic [W-1:0]  src_a, src_b;
  logic [2:0]    dst_lo_idx, dst_hi_idx;
  logic          busy, done, we_lo, we_hi, err;
  logic [W-1:0]  result_lo, result_hi;
  logic [3:0]    flags;
  logic [4:0]    upd_mask;

  int n_tests = 0;
  int n_fail  = 0;

  smul_flags_unit #(.DATA_W(W), .IDX_W(3)) u_dut (
    .clk(clk), .rst(rst), .start(start), .long_sel(long_sel), .wide_sel(wide_sel),
    .src_a(src_a), .src_b(src_b), .dst_lo_idx(dst_lo_idx), .dst_hi_idx(dst_hi_idx),
    .busy(busy), .done(done), .result_lo(result_lo), .result_hi(result_hi),
    .we_lo(we_lo), .we_hi(we_hi), .flags(flags), .upd_mask(upd_mask), .err(err)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // behavioural reference built from the requirements
  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic lng,
                       input logic wide, output logic [31:0] lo, output logic [31:0] hi,
                       output logic [3:0] f);
    longint pa, pb, p;
    logic n, z, v;
    pa = lng ? longint'($signed(a)) : longint'($signed(a[15:0]));
    pb = lng ? longint'($signed(b)) : longint'($signed(b[15:0]));
    p  = pa * pb;
    lo = p[31:0];
    hi = 32'h0;
    v  = 1'b0;
    n  = p[31];
    z  = (p[31:0] == 32'h0);
    if (lng && wide) begin
      hi = p[63:32];
      n  = p[63];
      z  = (p == 64'sd0);
    end else if (lng) begin
      v = (p != longint'($signed(p[31:0])));
    end
    f = {n, z, v, 1'b0};
  endtask

  // start one operation and wait for done; lat counts edges incl. the accepting one
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic lng,
                        input logic wide, input logic [2:0] li, input logic [2:0] hi_i,
                        output int lat);
    @(negedge clk);
    src_a = a; src_b = b; long_sel = lng; wide_sel = wide;
    dst_lo_idx = li; dst_hi_idx = hi_i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_vec(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic lng, input logic wide);
    logic [31:0] elo, ehi;
    logic [3:0]  ef;
    int lat;
    model(a, b, lng, wide, elo, ehi, ef);
    run_op(a, b, lng, wide, 3'd1, 3'd2, lat);
    check({tag, " R8 latency"}, 64'(lat), 64'(W + 1));
    check({tag, " R1/R2/R3 result_lo"}, {32'h0, result_lo}, {32'h0, elo});
    check({tag, " R3 result_hi"}, {32'h0, result_hi}, {32'h0, ehi});
    check({tag, " R4/R5/R6 flags NZVC"}, 64'(flags), 64'(ef));
    check({tag, " R3 write enables"}, {62'h0, we_lo, we_hi}, {62'h0, 1'b1, lng & wide});
    check({tag, " R6 upd_mask"}, 64'(upd_mask), 64'(5'b01111));
    check({tag, " R7 err low"}, 64'(err), 64'h0);
    check({tag, " R8 busy low at done"}, 64'(busy), 64'h0);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, {62'h0, done, we_lo}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int lat;
    int extra;
    rst = 1'b1; start = 1'b0; long_sel = 1'b0; wide_sel = 1'b0;
    src_a = '0; src_b = '0; dst_lo_idx = 3'd1; dst_hi_idx = 3'd2;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset busy/done/we/err", {60'h0, busy, done, we_lo, we_hi} | 64'(err), 64'h0);
    check("R10 reset results", {result_hi, result_lo}, 64'h0);
    check("R10 reset flags/mask", {55'h0, flags, upd_mask}, 64'h0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 corner operands
    for (int i = 0; i < NV; i++)
      check_vec($sformatf("vec%0d", i), VECS[i][65:34], VECS[i][33:2], VECS[i][1], VECS[i][0]);

    // random operands across all three forms
    for (int i = 0; i < 30; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      check_vec($sformatf("rnd%0d", i), ra, rb, (i % 3) != 0, (i % 3) == 2);
    end

    // R7: equal indices in wide form raise err and block writes
    run_op(32'h0000_0005, 32'h0000_0007, 1'b1, 1'b1, 3'd4, 3'd4, lat);
    check("R7 err with done", {62'h0, done, err}, 64'h3);
    check("R7 no writes", {62'h0, we_lo, we_hi}, 64'h0);
    check("R7 mask cleared", 64'(upd_mask), 64'h0);
    @(negedge clk);
    check("R7 err pulse ends", 64'(err), 64'h0);
    // R7: truncated form ignores equal indices
    run_op(32'h0000_0005, 32'h0000_0007, 1'b1, 1'b0, 3'd4, 3'd4, lat);
    check("R7 no err in truncated form", {62'h0, err, we_lo}, 64'h1);
    check("R7 truncated result", 64'(result_lo), 64'd35);

    // R9: start while busy is ignored
    @(negedge clk);
    src_a = 32'd7; src_b = 32'd6; long_sel = 1'b1; wide_sel = 1'b0;
    dst_lo_idx = 3'd1; dst_hi_idx = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after accept", 64'(busy), 64'h1);
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    src_a = 32'd100; src_b = 32'd100; wide_sel = 1'b1; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    check("R9 original latency kept", 64'(lat), 64'(W + 1));
    check("R9 original operands used", 64'(result_lo), 64'd42);
    check("R9 original form kept", {62'h0, we_lo, we_hi}, 64'h2);
    extra = 0;
    repeat (W + 5) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R9 no second done", 64'(extra), 64'h0);

    // R10: reset during an operation abandons it and clears results
    @(negedge clk);
    src_a = 32'd3; src_b = 32'd9; long_sel = 1'b1; wide_sel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid-run reset busy", {62'h0, busy, done}, 64'h0);
    check("R10 mid-run reset results", {result_hi, result_lo}, 64'h0);
    extra = 0;
    repeat (W + 5) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R10 abandoned op gives no done", 64'(extra), 64'h0);

    report();
  end

endmodule